// File: doc/BRIEF.md
# Span Edge Byte-Mask Generator

This block turns two byte addresses into a partial-store enable mask for the edge of a span. One address marks the first element to be written and the other marks the last. The element size (8, 16 or 32 bits) sets how many lanes one aligned 8-byte block holds: 8, 4 or 2. The byte order select decides whether lane 0 sits in the most significant mask bit (big-endian) or in the least significant bit (little-endian).

The lane index comes from the low address bits. The start address enables its own lane and every later lane in the block. The end address enables its own lane and every earlier lane. When both addresses fall in the same aligned 8-byte block, the result is the intersection of the two masks. Otherwise only the start mask is used.

An optional condition-code result gives the flags of start minus end, in both a 32-bit and a 64-bit view. In 32-bit mode only the block comparison uses truncated addresses. Results are registered and appear one cycle after the request.

Top module: `edge_mask_gen`

## Requirements
- R1: With `elem_size_i` = 0 (8-bit) and `little_i` = 0, lane k of 8 maps to mask bit 7-k. The lane index of each address is its bits 2:0. The start mask enables lanes at or above the start index, so an index of 3 gives 0x1F. The end mask enables lanes at or below the end index, so an index of 5 gives 0xFC. An `elem_size_i` value of 3 behaves as 8-bit.
- R2: With 8-bit elements and `little_i` = 1, lane k maps to mask bit k. The masks are the bit reversal of R1: start index 3 gives 0xF8 and end index 5 gives 0x3F.
- R3: With `elem_size_i` = 1 (16-bit), the lane index is address bits 2:1 and the mask is 4 bits wide. Lane k maps to bit 3-k for big-endian and to bit k for little-endian.
- R4: With `elem_size_i` = 2 (32-bit), the lane index is address bit 2 and the mask is 2 bits wide. Lane k maps to bit 1-k for big-endian and to bit k for little-endian.
- R5: When the two addresses agree in every bit from bit 3 upward, `mask_o` is the start mask AND the end mask. Otherwise `mask_o` is the start mask alone.
- R6: With `narrow_i` = 1, the same-block test compares only address bits 31:3.
- R7: With `cc_en_i` = 1, the result carries the flags of the full 64-bit subtraction start minus end. `xcc_o` holds the 64-bit view and `icc_o` the view on the low 32 bits. Each is packed as {N, Z, V, C}, where C is the unsigned borrow. The flags ignore `narrow_i`.
- R8: `cc_we_o` is high for exactly the result cycle of a request with `cc_en_i` = 1. In every other cycle `icc_o` and `xcc_o` keep their last values.
- R9: A request with `valid_i` = 1 gives `valid_o` = 1 and its mask on the next cycle. `mask_o` bits 63:8 are always zero. `mask_o` holds its value while no request arrives.
- R10: During reset `valid_o`, `cc_we_o`, `mask_o`, `icc_o` and `xcc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| addr_a_i | input | 64 | Start address |
| addr_b_i | input | 64 | End address |
| elem_size_i | input | 2 | Element size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 8-bit |
| little_i | input | 1 | Little-endian lane order |
| cc_en_i | input | 1 | Produce condition codes |
| narrow_i | input | 1 | 32-bit address mode |
| valid_o | output | 1 | Result valid |
| mask_o | output | 64 | Edge mask, zero-extended |
| cc_we_o | output | 1 | Condition-code write strobe |
| icc_o | output | 4 | 32-bit flags {N,Z,V,C} |
| xcc_o | output | 4 | 64-bit flags {N,Z,V,C} |

## Verification
The assertions assume that every input is at a known level at each rising clock edge and that reset is applied before the first request. They also assume that a size code of 3 is a legal alias for byte elements, not an error. The stimulus changes inputs only on falling edges. It keeps them defined throughout, including between requests. It draws the end address either inside the start address's block, in a nearby block, or with only the upper half changed, so that the 32-bit mode block comparison is tested both ways.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned NARROW_W = 32;
  localparam int unsigned MAX_LANES = 8;
  localparam int unsigned BLK_LSB  = $clog2(MAX_LANES);
  localparam int unsigned N_SIZES  = 3;

  typedef enum logic [1:0] {
    ESZ_B8  = 2'd0,
    ESZ_B16 = 2'd1,
    ESZ_B32 = 2'd2,
    ESZ_ALT = 2'd3
  } esize_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccflags_t;
endpackage

// File: rtl/edge_lane_mask.sv
module edge_lane_mask #(
  parameter int unsigned LANES = 8,
  localparam int unsigned IW   = $clog2(LANES)
) (
  input  logic [IW-1:0]    idx_a_i,
  input  logic [IW-1:0]    idx_b_i,
  input  logic             little_i,
  output logic [LANES-1:0] left_o,
  output logic [LANES-1:0] right_o
);
  for (genvar p = 0; p < LANES; p++) begin : g_bit
    localparam logic [IW-1:0] LANE_BE = IW'(LANES - 1 - p);
    localparam logic [IW-1:0] LANE_LE = IW'(p);
    logic [IW-1:0] lane;
    assign lane       = little_i ? LANE_LE : LANE_BE;
    assign left_o[p]  = (lane >= idx_a_i);
    assign right_o[p] = (lane <= idx_b_i);
  end

  // the last lane of a block is always in the start mask, lane 0 always in the end mask
  always_comb begin
    AST_LEFT_NONEMPTY: assert (left_o != '0); // R1
    AST_RIGHT_NONEMPTY: assert (right_o != '0); // R2
  end
endmodule

// File: rtl/edge_cc_calc.sv
module edge_cc_calc
  import edge_mask_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output ccflags_t     flags_o
);
  logic [W-1:0] diff;
  assign diff      = a_i - b_i;
  assign flags_o.n = diff[W-1];
  assign flags_o.z = (diff == '0);
  assign flags_o.v = (a_i[W-1] ^ b_i[W-1]) & (diff[W-1] ^ a_i[W-1]);
  assign flags_o.c = (a_i < b_i);
endmodule

// File: rtl/edge_mask_gen.sv
module edge_mask_gen
  import edge_mask_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [63:0] addr_a_i,
  input  logic [63:0] addr_b_i,
  input  logic [1:0]  elem_size_i,
  input  logic        little_i,
  input  logic        cc_en_i,
  input  logic        narrow_i,
  output logic        valid_o,
  output logic [63:0] mask_o,
  output logic        cc_we_o,
  output logic [3:0]  icc_o,
  output logic [3:0]  xcc_o
);
  logic [N_SIZES-1:0][MAX_LANES-1:0] left_v, right_v;

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    localparam int unsigned LN = MAX_LANES >> g;
    logic [LN-1:0] l_m, r_m;
    edge_lane_mask #(.LANES(LN)) u_lane (
      .idx_a_i (addr_a_i[BLK_LSB-1:g]),
      .idx_b_i (addr_b_i[BLK_LSB-1:g]),
      .little_i(little_i),
      .left_o  (l_m),
      .right_o (r_m)
    );
    assign left_v[g]  = MAX_LANES'(l_m);
    assign right_v[g] = MAX_LANES'(r_m);
  end

  logic [1:0] sel;
  always_comb begin
    unique case (esize_e'(elem_size_i))
      ESZ_B16: sel = 2'd1;
      ESZ_B32: sel = 2'd2;
      default: sel = 2'd0;
    endcase
  end

  logic same_blk;
  assign same_blk = narrow_i ? (addr_a_i[NARROW_W-1:BLK_LSB] == addr_b_i[NARROW_W-1:BLK_LSB])
                             : (addr_a_i[ADDR_W-1:BLK_LSB]   == addr_b_i[ADDR_W-1:BLK_LSB]);

  logic [MAX_LANES-1:0] mask_d;
  assign mask_d = same_blk ? (left_v[sel] & right_v[sel]) : left_v[sel];

  ccflags_t fl32, fl64;
  edge_cc_calc #(.W(NARROW_W)) u_cc32 (
    .a_i(addr_a_i[NARROW_W-1:0]), .b_i(addr_b_i[NARROW_W-1:0]), .flags_o(fl32));
  edge_cc_calc #(.W(ADDR_W)) u_cc64 (
    .a_i(addr_a_i), .b_i(addr_b_i), .flags_o(fl64));

  logic                 valid_q, cc_we_q;
  logic [MAX_LANES-1:0] mask_q;
  ccflags_t             icc_q, xcc_q;
  logic [1:0]           sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cc_we_q <= 1'b0;
      mask_q  <= '0;
      icc_q   <= '0;
      xcc_q   <= '0;
      sel_q   <= '0;
    end else begin
      valid_q <= valid_i;
      cc_we_q <= valid_i & cc_en_i;
      if (valid_i) begin
        mask_q <= mask_d;
        sel_q  <= sel;
      end
      if (valid_i && cc_en_i) begin
        icc_q <= fl32;
        xcc_q <= fl64;
      end
    end
  end

  assign valid_o = valid_q;
  assign cc_we_o = cc_we_q;
  assign mask_o  = ADDR_W'(mask_q);
  assign icc_o   = icc_q;
  assign xcc_o   = xcc_q;

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_STROBE_IN_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_we_o |-> valid_o); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cc_we_o |-> ($stable(icc_o) && $stable(xcc_o))); // R8
  AST_ZERO_BOTH_VIEWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_we_o && xcc_o[2]) |-> icc_o[2]); // R7
  AST_WORD_MASK_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sel_q == 2'd2) |-> (mask_o[7:2] == '0)); // R4
  AST_HALF_MASK_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sel_q == 2'd1) |-> (mask_o[7:4] == '0)); // R3
endmodule

// File: tb/edge_mask_gen_test.sv
module edge_mask_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [1:0]  sz_i = '0;
  logic        le_i = 1'b0, cc_i = 1'b0, nar_i = 1'b0;
  logic        valid_o, cc_we_o;
  logic [63:0] mask_o;
  logic [3:0]  icc_o, xcc_o;

  always #4 clk = ~clk;

  edge_mask_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .addr_a_i(a_i), .addr_b_i(b_i),
    .elem_size_i(sz_i), .little_i(le_i), .cc_en_i(cc_i), .narrow_i(nar_i),
    .valid_o(valid_o), .mask_o(mask_o), .cc_we_o(cc_we_o), .icc_o(icc_o), .xcc_o(xcc_o));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] ref_mask(logic [63:0] a, logic [63:0] b, logic [1:0] sz,
                                          logic le, logic nar);
    int lanes = (sz == 2'd1) ? 4 : (sz == 2'd2) ? 2 : 8;
    int bpl = 8 / lanes;
    int ia = int'(a[2:0]) / bpl;
    int ib = int'(b[2:0]) / bpl;
    logic same = nar ? (a[31:3] == b[31:3]) : (a[63:3] == b[63:3]);
    logic [7:0] m = '0;
    for (int k = 0; k < lanes; k++) begin
      int pos = le ? k : lanes - 1 - k;
      m[pos] = (k >= ia) && (!same || k <= ib);
    end
    return m;
  endfunction

  function automatic logic [3:0] ref_flags(logic [63:0] a, logic [63:0] b, int w);
    logic [64:0] du, ds;
    logic [64:0] ea, eb, sa, sb;
    if (w == 32) begin
      ea = {33'b0, a[31:0]}; eb = {33'b0, b[31:0]};
      sa = {{33{a[31]}}, a[31:0]}; sb = {{33{b[31]}}, b[31:0]};
      du = ea - eb; ds = sa - sb;
      return {du[31], du[31:0] == 32'b0, ds[32] != ds[31], du[64]};
    end
    ea = {1'b0, a}; eb = {1'b0, b};
    sa = {a[63], a}; sb = {b[63], b};
    du = ea - eb; ds = sa - sb;
    return {du[63], du[63:0] == 64'b0, ds[64] != ds[63], du[64]};
  endfunction

  // reference state, updated on the same edge as the design
  logic       e_valid = 1'b0, e_we = 1'b0;
  logic [7:0] e_mask = '0;
  logic [3:0] e_icc = '0, e_xcc = '0;
  string      e_tag = "R10", e_cctag = "R10";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= 1'b0; e_we <= 1'b0; e_mask <= '0; e_icc <= '0; e_xcc <= '0;
    end else begin
      e_valid <= valid_i;
      e_we    <= valid_i && cc_i;
      e_cctag <= (valid_i && cc_i) ? "R7" : "R8";
      if (valid_i) begin
        e_mask <= ref_mask(a_i, b_i, sz_i, le_i, nar_i);
        e_tag  <= (sz_i == 2'd1) ? "R3" : (sz_i == 2'd2) ? "R4" : (le_i ? "R2" : "R1");
      end
      if (valid_i && cc_i) begin
        e_icc <= ref_flags(a_i, b_i, 32);
        e_xcc <= ref_flags(a_i, b_i, 64);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 valid", {63'b0, valid_o}, {63'b0, e_valid});
      chk({e_tag, " mask"}, mask_o, {56'b0, e_mask});
      chk("R8 strobe", {63'b0, cc_we_o}, {63'b0, e_we});
      chk({e_cctag, " icc"}, {60'b0, icc_o}, {60'b0, e_icc});
      chk({e_cctag, " xcc"}, {60'b0, xcc_o}, {60'b0, e_xcc});
    end
  end

  task automatic op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                    input logic le, input logic cc, input logic nar);
    a_i = a; b_i = b; sz_i = sz; le_i = le; cc_i = cc; nar_i = nar; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 valid", {63'b0, valid_o}, 64'd0);
    chk("R10 mask", mask_o, 64'd0);
    chk("R10 strobe", {63'b0, cc_we_o}, 64'd0);
    chk("R10 flags", {56'b0, icc_o, xcc_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    op(64'h1003, 64'h100D, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R1 start idx3", mask_o, 64'h1F);
    op(64'h1003, 64'h100D, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R2 start idx3", mask_o, 64'hF8);
    op(64'h1003, 64'h1005, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R5 same block", mask_o, 64'h1C);
    op(64'h1003, 64'h1005, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R5 same block le", mask_o, 64'h38);
    op(64'h1002, 64'h1004, 2'd1, 1'b0, 1'b0, 1'b0);
    chk("R3 half be", mask_o, 64'h6);
    op(64'h1004, 64'h1004, 2'd2, 1'b1, 1'b0, 1'b0);
    chk("R4 word le", mask_o, 64'h2);
    op(64'h1_0000_1003, 64'h2_0000_1005, 2'd0, 1'b0, 1'b1, 1'b1);
    chk("R6 narrow same", mask_o, 64'h1C);
    chk("R7 xcc", {60'b0, xcc_o}, 64'h9);
    chk("R7 icc", {60'b0, icc_o}, 64'h9);
    op(64'h1_0000_1003, 64'h2_0000_1005, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R6 wide differ", mask_o, 64'h1F);
    chk("R8 flags kept", {56'b0, icc_o, xcc_o}, 64'h99);
    op(64'h1_0000_0005, 64'h5, 2'd0, 1'b0, 1'b1, 1'b0);
    chk("R7 low zero", {56'b0, icc_o, xcc_o}, 64'h40);
    op(64'h8000_0000_0000_0000, 64'h1, 2'd3, 1'b0, 1'b1, 1'b0);
    chk("R7 overflow xcc", {60'b0, xcc_o}, 64'h2);
    chk("R1 alias size", mask_o, 64'hFF);

    for (int i = 0; i < 4000; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      case ($urandom % 4)
        0: b = {a[63:3], 3'($urandom)};
        1: b = a + 64'($urandom % 24);
        2: b = {32'($urandom), a[31:3], 3'($urandom)};
        default: b = {$urandom, $urandom};
      endcase
      a_i = a; b_i = b; sz_i = 2'($urandom); le_i = 1'($urandom);
      cc_i = 1'($urandom); nar_i = 1'($urandom); valid_i = ($urandom % 4) != 0;
      @(negedge clk);
    end
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule